// File: doc/BRIEF.md
# Event State Buffer Load Controller

This block holds the interrupt-coalescing state of a table of event queue descriptors. Every descriptor carries two 2-bit P/Q fields. The notification field gates whether an incoming event is passed downstream. The escalation field is kept for the escalation path. Both fields sit in a register array inside the block.

Software reaches the fields through a load-only window. Each descriptor owns an even page and an odd page. The even page acts on the notification field and the odd page acts on the escalation field. The low address bits of a load choose what the load does: an end-of-interrupt step, a plain status read, or a forced write of one of the four P/Q codes.

A separate trigger port feeds events for a descriptor index. When the descriptor is not in unconditional mode, the trigger step runs on its notification field. A notification pulse leaves the block only when that step reports one. When the descriptor is in unconditional mode, the pulse always leaves and the field is left alone.

Top module: `esb_mmio_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `notify_out` are 0 and every P/Q field of every descriptor is 00.
- R2: The descriptor index of a load is `req_addr >> (SHIFT+1)`. Address bit `SHIFT` selects the field: 0 selects the notification field and 1 selects the escalation field.
- R3: The operation is decoded from address bits [11:0]. If bit 11 is 0, the load is an EOI. If bits [11:10] are 10, the load is a GET, which returns the current P/Q and leaves the field unchanged. If bits [11:10] are 11, the load is a SET that forces P/Q to bits [9:8] and returns the previous P/Q.
- R4: EOI moves 00 and 10 to 00 and returns 0. It keeps 01 and returns 0. It moves 11 to 10 and returns 1.
- R5: A store (`req_write`=1) is answered with `rsp_err`=1 and all-ones data, and it changes no field.
- R6: A load whose `req_size` is not 8 is answered with `rsp_err`=1 and all-ones data, and it changes no field.
- R7: A load to an index of `N_DESC` or more, or to a descriptor whose `desc_valid` bit is 0, is answered with `rsp_err`=1 and all-ones data, and it changes no field.
- R8: Successful load data is the 64-bit result in big-endian byte order. The P/Q value or EOI flag therefore appears in `rsp_data[57:56]` and every other bit is 0. `rsp_err` is 0 for a successful load.
- R9: Every request cycle on `req_valid` gives exactly one `rsp_valid` cycle on the next clock. No response appears without a request.
- R10: In a trigger on a valid, non-unconditional descriptor, 00 goes to 10 with a notify. 01 stays 01, and 10 and 11 go to 11, all without a notify. `notify_out` and `notify_idx` appear one clock after `trig_valid`.
- R11: A trigger on a valid descriptor with `desc_ucond`=1 always raises `notify_out` and leaves its notification field unchanged.
- R12: A trigger on an index of `N_DESC` or more, or on an invalid descriptor, raises no notify and changes no field.
- R13: When a successful load and a trigger hit the same notification field in one cycle, the load acts first and the trigger step acts on its result. The load data reflects the field before the trigger.
- R14: A field keeps its value in every cycle that carries no accepted load and no trigger on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | N_DESC | Per-descriptor valid bit |
| desc_ucond | input | N_DESC | Per-descriptor unconditional-notify bit |
| req_valid | input | 1 | Window access request |
| req_write | input | 1 | Access is a store |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_size | input | 4 | Access width in bytes |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_data | output | 64 | Big-endian load result |
| rsp_err | output | 1 | Access rejected |
| trig_valid | input | 1 | Event trigger strobe |
| trig_idx | input | IDX_W | Descriptor index of the trigger |
| notify_out | output | 1 | Forward the event downstream |
| notify_idx | output | IDX_W | Descriptor index of the forwarded event |

## Verification
The assertions assume that `req_write`, `req_size` and `req_addr` are known whenever `req_valid` is high. They also assume that `desc_valid` and `desc_ucond` change only between transfers and never inside a cycle that is being decoded. The stimulus drives all request and trigger fields at the falling edge and holds the descriptor bits steady across each sampled edge. It draws addresses that cover the in-range, out-of-range, even and odd page cases and every operation region. Many cycles in the stimulus carry a load and a trigger on the same descriptor together.

// File: rtl/esb_pkg.sv
package esb_pkg;

  localparam int unsigned DATA_W     = 64;
  localparam int unsigned WORD_BYTES = DATA_W / 8;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_00 = 2'b00;
  localparam pq_t PQ_01 = 2'b01;
  localparam pq_t PQ_10 = 2'b10;
  localparam pq_t PQ_11 = 2'b11;

  typedef enum logic [1:0] {
    OP_EOI = 2'd0,
    OP_GET = 2'd1,
    OP_SET = 2'd2
  } op_e;

  typedef struct packed {
    pq_t  nxt;
    logic flag;
  } pq_res_t;

  // event arrival: only the idle code forwards
  function automatic pq_res_t pq_trigger(input pq_t cur);
    pq_res_t r;
    unique case (cur)
      PQ_00:   begin r.nxt = PQ_10; r.flag = 1'b1; end
      PQ_01:   begin r.nxt = PQ_01; r.flag = 1'b0; end
      default: begin r.nxt = PQ_11; r.flag = 1'b0; end
    endcase
    return r;
  endfunction

  // end of interrupt: a queued event asks for a replay
  function automatic pq_res_t pq_eoi(input pq_t cur);
    pq_res_t r;
    unique case (cur)
      PQ_01:   begin r.nxt = PQ_01; r.flag = 1'b0; end
      PQ_11:   begin r.nxt = PQ_10; r.flag = 1'b1; end
      default: begin r.nxt = PQ_00; r.flag = 1'b0; end
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] to_big_endian(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] s;
    for (int b = 0; b < int'(WORD_BYTES); b++) begin
      s[8*b +: 8] = v[8*(int'(WORD_BYTES)-1-b) +: 8];
    end
    return s;
  endfunction

endpackage

// File: rtl/esb_decode.sv
module esb_decode
  import esb_pkg::*;
#(
  parameter int unsigned SHIFT  = 12,
  parameter int unsigned N_DESC = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              odd_page,
  output op_e               op,
  output pq_t               set_val
);

  localparam int unsigned OFF_W = 12;

  logic [ADDR_W-1:0] slot;
  logic [OFF_W-1:0]  off;

  assign slot     = addr >> (SHIFT + 1);
  assign in_range = (slot < ADDR_W'(N_DESC));
  assign idx      = slot[IDX_W-1:0];
  assign odd_page = addr[SHIFT];
  assign off      = addr[OFF_W-1:0];
  assign set_val  = off[9:8];

  always_comb begin
    if (!off[11])             op = OP_EOI;
    else if (off[10:10] == 1'b0) op = OP_GET;
    else                      op = OP_SET;
  end

endmodule

// File: rtl/esb_state_array.sv
module esb_state_array
  import esb_pkg::*;
#(
  parameter int unsigned N_DESC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_DESC-1:0]   n_we,
  input  logic [2*N_DESC-1:0] n_wd,
  input  logic [N_DESC-1:0]   e_we,
  input  logic [2*N_DESC-1:0] e_wd,
  output logic [2*N_DESC-1:0] n_q,
  output logic [2*N_DESC-1:0] e_q
);

  for (genvar d = 0; d < int'(N_DESC); d++) begin : g_desc
    pq_t n_r;
    pq_t e_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_r <= PQ_00;
      end else if (n_we[d]) begin
        n_r <= n_wd[2*d +: 2];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_r <= PQ_00;
      end else if (e_we[d]) begin
        e_r <= e_wd[2*d +: 2];
      end
    end

    assign n_q[2*d +: 2] = n_r;
    assign e_q[2*d +: 2] = e_r;
  end

endmodule

// File: rtl/esb_mmio_ctrl.sv
module esb_mmio_ctrl
  import esb_pkg::*;
#(
  parameter int unsigned SHIFT  = 12,
  parameter int unsigned N_DESC = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DESC-1:0] desc_valid,
  input  logic [N_DESC-1:0] desc_ucond,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_err,
  input  logic              trig_valid,
  input  logic [IDX_W-1:0]  trig_idx,
  output logic              notify_out,
  output logic [IDX_W-1:0]  notify_idx
);

  if ((SHIFT != 12) && (SHIFT != 16)) begin : g_bad_shift
    $error("esb_mmio_ctrl: SHIFT must be 12 or 16");
  end
  if (N_DESC < 1) begin : g_bad_count
    $error("esb_mmio_ctrl: N_DESC must be at least 1");
  end
  if (ADDR_W < SHIFT + 1 + IDX_W) begin : g_bad_addr
    $error("esb_mmio_ctrl: ADDR_W too narrow for the window");
  end

  localparam logic [3:0] ACCESS_BYTES = 4'(WORD_BYTES);

  // decode
  logic [IDX_W-1:0] d_idx;
  logic             d_in;
  logic             d_odd;
  op_e              d_op;
  pq_t              d_setv;

  esb_decode #(
    .SHIFT (SHIFT),
    .N_DESC(N_DESC),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) i_decode (
    .addr    (req_addr),
    .idx     (d_idx),
    .in_range(d_in),
    .odd_page(d_odd),
    .op      (d_op),
    .set_val (d_setv)
  );

  // state array
  logic [N_DESC-1:0]   n_we;
  logic [N_DESC-1:0]   e_we;
  logic [2*N_DESC-1:0] n_wd;
  logic [2*N_DESC-1:0] e_wd;
  logic [2*N_DESC-1:0] npq_all;
  logic [2*N_DESC-1:0] epq_all;

  esb_state_array #(
    .N_DESC(N_DESC)
  ) i_state (
    .clk  (clk),
    .rst_n(rst_n),
    .n_we (n_we),
    .n_wd (n_wd),
    .e_we (e_we),
    .e_wd (e_wd),
    .n_q  (npq_all),
    .e_q  (epq_all)
  );

  // load acceptance and operation
  logic              sel_valid;
  logic              acc;
  pq_t               cur_pq;
  pq_t               mm_new;
  logic [DATA_W-1:0] mm_val;
  pq_res_t           eoi_res;

  always_comb begin
    sel_valid = 1'b0;
    cur_pq    = PQ_00;
    if (d_in) begin
      sel_valid = desc_valid[d_idx];
      cur_pq    = d_odd ? epq_all[2*d_idx +: 2] : npq_all[2*d_idx +: 2];
    end
  end

  assign acc     = req_valid && !req_write && (req_size == ACCESS_BYTES) && d_in && sel_valid;
  assign eoi_res = pq_eoi(cur_pq);

  always_comb begin
    unique case (d_op)
      OP_EOI: begin
        mm_new = eoi_res.nxt;
        mm_val = DATA_W'(eoi_res.flag);
      end
      OP_GET: begin
        mm_new = cur_pq;
        mm_val = DATA_W'(cur_pq);
      end
      default: begin
        mm_new = d_setv;
        mm_val = DATA_W'(cur_pq);
      end
    endcase
  end

  // trigger acceptance
  logic t_ok;
  always_comb begin
    t_ok = 1'b0;
    if (trig_valid && (int'(trig_idx) < int'(N_DESC))) begin
      t_ok = desc_valid[trig_idx];
    end
  end

  // per-descriptor next state: load first, then trigger
  logic [N_DESC-1:0] t_flag;

  for (genvar d = 0; d < int'(N_DESC); d++) begin : g_next
    pq_t     n_cur;
    pq_t     e_cur;
    pq_t     n_mid;
    pq_t     n_nxt;
    pq_t     e_nxt;
    pq_res_t tr;
    logic    mm_hit;
    logic    t_hit;

    assign n_cur  = npq_all[2*d +: 2];
    assign e_cur  = epq_all[2*d +: 2];
    assign mm_hit = acc && (d_idx == IDX_W'(d));
    assign t_hit  = t_ok && (trig_idx == IDX_W'(d));

    always_comb begin
      n_mid = (mm_hit && !d_odd) ? mm_new : n_cur;
      e_nxt = (mm_hit &&  d_odd) ? mm_new : e_cur;
      tr    = pq_trigger(n_mid);
      n_nxt = (t_hit && !desc_ucond[d]) ? tr.nxt : n_mid;
    end

    assign n_we[d]         = (n_nxt != n_cur);
    assign e_we[d]         = (e_nxt != e_cur);
    assign n_wd[2*d +: 2]  = n_nxt;
    assign e_wd[2*d +: 2]  = e_nxt;
    assign t_flag[d]       = t_hit && (desc_ucond[d] || tr.flag);
  end

  // response and notify next state
  logic              rsp_valid_d;
  logic              rsp_err_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              notify_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && !acc;
    rsp_data_d  = acc ? to_big_endian(mm_val) : '1;
    notify_d    = |t_flag;
  end

  logic              rsp_valid_q;
  logic              rsp_err_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              notify_q;
  logic [IDX_W-1:0]  notify_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      notify_q    <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      notify_q    <= notify_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q <= '0;
    end else if (req_valid) begin
      rsp_data_q <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_idx_q <= '0;
    end else if (trig_valid) begin
      notify_idx_q <= trig_idx;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_err    = rsp_err_q;
  assign rsp_data   = rsp_data_q;
  assign notify_out = notify_q;
  assign notify_idx = notify_idx_q;

endmodule

// File: rtl/esb_mmio_chk.sv
module esb_mmio_chk #(
  parameter int unsigned N_DESC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [3:0]          req_size,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic [63:0]         rsp_data,
  input logic                trig_valid,
  input logic                notify_out,
  input logic [2*N_DESC-1:0] npq_all,
  input logic [2*N_DESC-1:0] epq_all
);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R5
  store_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_err && (rsp_data == '1)));

  // R5
  store_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !trig_valid) |=> ($stable(npq_all) && $stable(epq_all)));

  // R6
  size_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_size != 4'd8)) |=> rsp_err);

  // R8
  load_data_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> ((rsp_data[63:58] == '0) && (rsp_data[55:0] == '0)));

  // R10
  notify_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_out |-> $past(trig_valid));

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !trig_valid) |=> ($stable(npq_all) && $stable(epq_all)));

endmodule

bind esb_mmio_ctrl esb_mmio_chk #(
  .N_DESC(N_DESC)
) i_esb_mmio_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .trig_valid(trig_valid),
  .notify_out(notify_out),
  .npq_all   (npq_all),
  .epq_all   (epq_all)
);

// File: tb/test_esb_mmio_ctrl.sv
module test_esb_mmio_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT  = 12;
  localparam int N_DESC = 3;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 2;

  logic              clk;
  logic              rst_n;
  logic [N_DESC-1:0] desc_valid;
  logic [N_DESC-1:0] desc_ucond;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_size;
  logic              rsp_valid;
  logic [63:0]       rsp_data;
  logic              rsp_err;
  logic              trig_valid;
  logic [IDX_W-1:0]  trig_idx;
  logic              notify_out;
  logic [IDX_W-1:0]  notify_idx;

  esb_mmio_ctrl #(
    .SHIFT (SHIFT),
    .N_DESC(N_DESC),
    .ADDR_W(ADDR_W)
  ) i_esb_mmio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_valid(desc_valid),
    .desc_ucond(desc_ucond),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .trig_valid(trig_valid),
    .trig_idx  (trig_idx),
    .notify_out(notify_out),
    .notify_idx(notify_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0] mn [N_DESC];
  logic [1:0] me [N_DESC];

  // offsets inside a page
  localparam logic [11:0] OFF_EOI = 12'h000;
  localparam logic [11:0] OFF_GET = 12'h800;
  localparam logic [11:0] OFF_S00 = 12'hC00;
  localparam logic [11:0] OFF_S01 = 12'hD00;
  localparam logic [11:0] OFF_S10 = 12'hE00;
  localparam logic [11:0] OFF_S11 = 12'hF00;

  function automatic logic [63:0] swap64(input logic [63:0] v);
    logic [63:0] s;
    for (int b = 0; b < 8; b++) s[8*b +: 8] = v[8*(7-b) +: 8];
    return s;
  endfunction

  // {next, flag}
  function automatic logic [2:0] exp_trig(input logic [1:0] c);
    case (c)
      2'b00:   return {2'b10, 1'b1};
      2'b01:   return {2'b01, 1'b0};
      default: return {2'b11, 1'b0};
    endcase
  endfunction

  function automatic logic [2:0] exp_eoi(input logic [1:0] c);
    case (c)
      2'b01:   return {2'b01, 1'b0};
      2'b11:   return {2'b10, 1'b1};
      default: return {2'b00, 1'b0};
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int idx, input bit odd, input logic [11:0] off);
    return (ADDR_W'(idx) << (SHIFT + 1)) | (ADDR_W'(odd) << SHIFT) | ADDR_W'(off);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: optional request and optional trigger, then check outputs
  task automatic step(input bit do_r, input bit wr, input logic [ADDR_W-1:0] addr,
                      input logic [3:0] size, input bit do_t, input int tidx, input string tag);
    int          idx;
    bit          odd;
    logic [11:0] off;
    bit          acc;
    logic [1:0]  cur;
    logic [1:0]  nxt;
    logic [63:0] val;
    logic [63:0] exp_data;
    bit          exp_err;
    bit          t_ok;
    bit          exp_ntf;
    logic [2:0]  r;
    string       rtag;
    string       ttag;

    idx = int'(addr >> (SHIFT + 1));
    odd = addr[SHIFT];
    off = addr[11:0];
    acc = do_r && !wr && (size == 4'd8) && (idx < N_DESC) && desc_valid[idx % N_DESC];
    exp_data = '1;
    exp_err  = do_r && !acc;
    val      = '0;
    if (wr)                    rtag = "R5";
    else if (size != 4'd8)     rtag = "R6";
    else if (!acc)             rtag = "R7";
    else if (!off[11])         rtag = "R4";
    else                       rtag = "R3";
    if (acc) begin
      cur = odd ? me[idx] : mn[idx];
      if (!off[11]) begin
        r = exp_eoi(cur); nxt = r[2:1]; val = 64'(r[0]);
      end else if (!off[10]) begin
        nxt = cur; val = 64'(cur);
      end else begin
        nxt = off[9:8]; val = 64'(cur);
      end
      if (odd) me[idx] = nxt; else mn[idx] = nxt;
      exp_data = swap64(val);
    end
    t_ok = do_t && (tidx < N_DESC) && desc_valid[tidx % N_DESC];
    exp_ntf = 1'b0;
    if (!t_ok)                      ttag = "R12";
    else if (desc_ucond[tidx])      ttag = "R11";
    else if (acc && !odd && idx == tidx) ttag = "R13";
    else                            ttag = "R10";
    if (t_ok) begin
      if (desc_ucond[tidx]) begin
        exp_ntf = 1'b1;
      end else begin
        r = exp_trig(mn[tidx]);
        mn[tidx] = r[2:1];
        exp_ntf  = r[0];
      end
    end
    if (tag != "") begin rtag = tag; ttag = tag; end

    req_valid  = do_r;
    req_write  = wr;
    req_addr   = addr;
    req_size   = size;
    trig_valid = do_t;
    trig_idx   = IDX_W'(tidx);
    @(negedge clk);
    check(rsp_valid == do_r, "R9", 64'(rsp_valid), 64'(do_r));
    if (do_r) begin
      check(rsp_err == exp_err, rtag, 64'(rsp_err), 64'(exp_err));
      check(rsp_data == exp_data, rtag, rsp_data, exp_data);
    end
    check(notify_out == exp_ntf, ttag, 64'(notify_out), 64'(exp_ntf));
    if (exp_ntf) check(notify_idx == IDX_W'(tidx), ttag, 64'(notify_idx), 64'(tidx));
    req_valid  = 1'b0;
    req_write  = 1'b0;
    trig_valid = 1'b0;
  endtask

  task automatic get_chk(input int idx, input bit odd, input string tag);
    step(1'b1, 1'b0, mk_addr(idx, odd, OFF_GET), 4'd8, 1'b0, 0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n      = 1'b0;
    desc_valid = '1;
    desc_ucond = '0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_addr   = '0;
    req_size   = 4'd8;
    trig_valid = 1'b0;
    trig_idx   = '0;
    for (int d = 0; d < N_DESC; d++) begin mn[d] = 2'b00; me[d] = 2'b00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
    check(notify_out == 1'b0, "R1", 64'(notify_out), 64'd0);
    for (int d = 0; d < N_DESC; d++) begin
      get_chk(d, 1'b0, "R1");
      get_chk(d, 1'b1, "R1");
    end

    // R2 even/odd pages reach separate fields
    step(1'b1, 1'b0, mk_addr(1, 1'b1, OFF_S11), 4'd8, 1'b0, 0, "R2");
    get_chk(1, 1'b0, "R2");
    get_chk(1, 1'b1, "R2");

    // R8 big-endian placement of 11
    step(1'b1, 1'b0, mk_addr(1, 1'b1, OFF_GET), 4'd8, 1'b0, 0, "R8");
    check(rsp_data == 64'h0300_0000_0000_0000, "R8", rsp_data, 64'h0300_0000_0000_0000);

    // R4 EOI from 11 returns 1 and lands at 10; from 10 to 00
    step(1'b1, 1'b0, mk_addr(1, 1'b1, OFF_EOI + 12'h7F8), 4'd8, 1'b0, 0, "R4");
    get_chk(1, 1'b1, "R4");
    step(1'b1, 1'b0, mk_addr(1, 1'b1, OFF_EOI), 4'd8, 1'b0, 0, "R4");
    step(1'b1, 1'b0, mk_addr(0, 1'b0, OFF_S01), 4'd8, 1'b0, 0, "R3");
    step(1'b1, 1'b0, mk_addr(0, 1'b0, OFF_EOI), 4'd8, 1'b0, 0, "R4");
    step(1'b1, 1'b0, mk_addr(0, 1'b0, OFF_S10 + 12'h0F8), 4'd8, 1'b0, 0, "R3");
    step(1'b1, 1'b0, mk_addr(0, 1'b0, OFF_S00), 4'd8, 1'b0, 0, "R3");

    // R14 repeated GET leaves the field as is
    get_chk(0, 1'b0, "R14");
    get_chk(0, 1'b0, "R14");

    // R5 store, R6 wrong size, R7 out of range and invalid
    step(1'b1, 1'b1, mk_addr(2, 1'b0, OFF_S11), 4'd8, 1'b0, 0, "R5");
    get_chk(2, 1'b0, "R5");
    step(1'b1, 1'b0, mk_addr(2, 1'b0, OFF_S11), 4'd4, 1'b0, 0, "R6");
    get_chk(2, 1'b0, "R6");
    step(1'b1, 1'b0, mk_addr(3, 1'b0, OFF_GET), 4'd8, 1'b0, 0, "R7");
    desc_valid = 3'b011;
    step(1'b1, 1'b0, mk_addr(2, 1'b0, OFF_S11), 4'd8, 1'b0, 0, "R7");
    desc_valid = 3'b111;
    get_chk(2, 1'b0, "R7");

    // R9 idle cycle gives no response
    step(1'b0, 1'b0, '0, 4'd8, 1'b0, 0, "R9");

    // R10 trigger walk 00 -> 10 -> 11 -> 11
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 2, "R10");
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 2, "R10");
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 2, "R10");
    get_chk(2, 1'b0, "R10");

    // R11 unconditional
    desc_ucond = 3'b001;
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 0, "R11");
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 0, "R11");
    get_chk(0, 1'b0, "R11");
    desc_ucond = 3'b000;

    // R12 out of range and invalid trigger
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 3, "R12");
    desc_valid = 3'b110;
    step(1'b0, 1'b0, '0, 4'd8, 1'b1, 0, "R12");
    desc_valid = 3'b111;
    get_chk(0, 1'b0, "R12");

    // R13 same-cycle EOI and trigger on one notification field
    step(1'b1, 1'b0, mk_addr(2, 1'b0, OFF_EOI), 4'd8, 1'b1, 2, "R13");
    get_chk(2, 1'b0, "R13");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int          ridx;
      logic [11:0] roff;
      logic [3:0]  rsz;
      if ($urandom_range(0, 15) == 0) desc_valid = N_DESC'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) desc_ucond = N_DESC'($urandom_range(0, 7));
      ridx = $urandom_range(0, 3);
      case ($urandom_range(0, 5))
        0: roff = OFF_EOI | 12'($urandom_range(0, 12'h7FF));
        1: roff = OFF_GET | 12'($urandom_range(0, 12'h3FF));
        2: roff = OFF_S00 | 12'($urandom_range(0, 12'hFF));
        3: roff = OFF_S01 | 12'($urandom_range(0, 12'hFF));
        4: roff = OFF_S10 | 12'($urandom_range(0, 12'hFF));
        default: roff = OFF_S11 | 12'($urandom_range(0, 12'hFF));
      endcase
      rsz = ($urandom_range(0, 19) == 0) ? 4'd4 : 4'd8;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 19) == 0,
           mk_addr(ridx, 1'($urandom_range(0, 1)), roff), rsz,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3), "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule